// File: doc/BRIEF.md
# Two-Phase Add-Rotate-XOR Mixing Unit

This block computes one half of the 32-bit add-rotate-xor mixing step used in every round of a 14-round hash compression. It takes four state words A, B, C and D together with one pre-combined word CM. CM is a message word already XORed with its round constant. It returns the four updated words. A one-bit phase input picks the rotation pair. Phase 0 uses right rotations of 16 and 12. Phase 1 uses right rotations of 8 and 7. To form a complete mixing function, the caller runs phase 0 and then runs phase 1 on its results with the second CM word.

The arithmetic chain has a register in its middle. The first stage forms the new A and the new D. The second stage forms the new C and the new B. Every request therefore finishes a fixed two clock edges after it is accepted. One request can enter on every cycle, and that includes the cycle in which an earlier result is signalled done. Address generation for message words, state storage and round sequencing belong to the surrounding controller.

Top module: `arx_half_mix`

## Requirements
- R1: While reset is high, and on the first cycle after it, done is 0 and all four result outputs are 0.
- R2: The A result equals A + B + CM modulo 2^32.
- R3: The D result equals (D XOR new A) rotated right by the first rotation amount.
- R4: The C result equals C + new D modulo 2^32.
- R5: The B result equals (B XOR new C) rotated right by the second rotation amount, where B is the original input B.
- R6: Phase 0 selects the rotation pair (16, 12) and phase 1 selects (8, 7). For example, with D=1 and all other inputs 0, phase 0 gives B=0x00000010 and D=0x00010000, and phase 1 gives B=0x00020000 and D=0x01000000.
- R7: When start is sampled high at a rising edge, done is high for exactly one cycle after the next rising edge, and the results are valid in that same cycle.
- R8: A start is accepted on every cycle, including a cycle in which done is high. Back-to-back requests complete in order, one per cycle.
- R9: While done is low, the four result outputs hold their last values.
- R10: A phase 0 call with CM0, followed by a phase 1 call on its results with CM1, equals the full mixing function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new request this cycle |
| phase | input | 1 | Rotation pair select: 0 gives (16,12), 1 gives (8,7) |
| a_in | input | 32 | State word A |
| b_in | input | 32 | State word B |
| c_in | input | 32 | State word C |
| d_in | input | 32 | State word D |
| cm_in | input | 32 | Message word XOR round constant |
| done | output | 1 | One-cycle pulse: results valid |
| a_out | output | 32 | Updated A |
| b_out | output | 32 | Updated B |
| c_out | output | 32 | Updated C |
| d_out | output | 32 | Updated D |

## Verification
A wrong value in the first-stage register shows up in d_out and a_out in the cycle that done rises. It also spreads into c_out and b_out in that same cycle, because the second stage builds on it. A lost or duplicated valid bit shows as a done pulse that is missing, early or extra, so a result goes out of order compared with the queued requests within one cycle. Corrupt held results show as a change on the outputs while done is low. The bench compares every port on every cycle, so any of these faults is reported in the cycle where it first appears.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int WORD_W = 32;
    localparam int ROT_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ROT_W-1:0]  rot_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } quad_t;

    typedef struct packed {
        rot_t first;
        rot_t second;
    } rot_pair_t;

    typedef enum logic {
        PH_WIDE   = 1'b0,
        PH_NARROW = 1'b1
    } phase_e;

    function automatic word_t rot_right(word_t x, rot_t r);
        word_t lo;
        word_t hi;
        lo = x >> r;
        hi = x << (ROT_W'(WORD_W - 1) - r + 1'b1);
        return (r == '0) ? x : (lo | hi);
    endfunction

    function automatic word_t rot_left(word_t x, rot_t r);
        word_t lo;
        word_t hi;
        hi = x << r;
        lo = x >> (ROT_W'(WORD_W - 1) - r + 1'b1);
        return (r == '0) ? x : (hi | lo);
    endfunction

endpackage

// File: rtl/arx_rot_select.sv
module arx_rot_select
    import arx_pkg::*;
#(
    parameter int WIDE_R1   = 16,
    parameter int WIDE_R2   = 12,
    parameter int NARROW_R1 = 8,
    parameter int NARROW_R2 = 7
) (
    input  phase_e    phase_i,
    output rot_pair_t rot_o
);

    localparam rot_pair_t WIDE_PAIR   = '{first: rot_t'(WIDE_R1),   second: rot_t'(WIDE_R2)};
    localparam rot_pair_t NARROW_PAIR = '{first: rot_t'(NARROW_R1), second: rot_t'(NARROW_R2)};

    always_comb begin
        unique case (phase_i)
            PH_WIDE:   rot_o = WIDE_PAIR;
            PH_NARROW: rot_o = NARROW_PAIR;
            default:   rot_o = WIDE_PAIR;
        endcase
    end

endmodule

// File: rtl/arx_front_stage.sv
module arx_front_stage
    import arx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  quad_t q_i,
    input  word_t cm_i,
    input  rot_pair_t rot_i,
    output logic  out_valid,
    output quad_t q_o,
    output rot_t  r2_o
);

    word_t a_sum;
    word_t d_mix;

    always_comb begin
        a_sum = q_i.a + q_i.b + cm_i;
        d_mix = rot_right(q_i.d ^ a_sum, rot_i.first);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q_o       <= '0;
            r2_o      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                q_o.a <= a_sum;
                q_o.b <= q_i.b;
                q_o.c <= q_i.c;
                q_o.d <= d_mix;
                r2_o  <= rot_i.second;
            end
        end
    end

    // R3: undoing the rotation and the xor with the new A must give back the original D
    p_d_inverse_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((rot_left(q_o.d, $past(rot_i.first)) ^ q_o.a) == $past(q_i.d)));

    // R2: the new A minus B and CM must give back the original A
    p_a_inverse_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((q_o.a - $past(q_i.b) - $past(cm_i)) == $past(q_i.a)));

endmodule

// File: rtl/arx_back_stage.sv
module arx_back_stage
    import arx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  quad_t q_i,
    input  rot_t  r2_i,
    output logic  done_o,
    output quad_t q_o
);

    word_t c_sum;
    word_t b_mix;

    always_comb begin
        c_sum = q_i.c + q_i.d;
        b_mix = rot_right(q_i.b ^ c_sum, r2_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            q_o    <= '0;
        end else begin
            done_o <= in_valid;
            if (in_valid) begin
                q_o.a <= q_i.a;
                q_o.b <= b_mix;
                q_o.c <= c_sum;
                q_o.d <= q_i.d;
            end
        end
    end

    // R5: undoing the rotation and the xor with the new C must give back the original B
    p_b_inverse_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((rot_left(q_o.b, $past(r2_i)) ^ q_o.c) == $past(q_i.b)));

    // R4: the new C minus the new D must give back the original C
    p_c_inverse_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((q_o.c - q_o.d) == $past(q_i.c)));

    // R9: results hold while no completion is signalled
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(q_o));

endmodule

// File: rtl/arx_half_mix.sv
module arx_half_mix
    import arx_pkg::*;
#(
    parameter int WIDE_R1   = 16,
    parameter int WIDE_R2   = 12,
    parameter int NARROW_R1 = 8,
    parameter int NARROW_R2 = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              phase,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic [WORD_W-1:0] c_in,
    input  logic [WORD_W-1:0] d_in,
    input  logic [WORD_W-1:0] cm_in,
    output logic              done,
    output logic [WORD_W-1:0] a_out,
    output logic [WORD_W-1:0] b_out,
    output logic [WORD_W-1:0] c_out,
    output logic [WORD_W-1:0] d_out
);

    quad_t     q_in;
    quad_t     q_mid;
    quad_t     q_res;
    rot_pair_t rot_sel;
    rot_t      r2_mid;
    logic      mid_valid;

    assign q_in = '{a: a_in, b: b_in, c: c_in, d: d_in};

    arx_rot_select #(
        .WIDE_R1  (WIDE_R1),
        .WIDE_R2  (WIDE_R2),
        .NARROW_R1(NARROW_R1),
        .NARROW_R2(NARROW_R2)
    ) u_rot (
        .phase_i(phase_e'(phase)),
        .rot_o  (rot_sel)
    );

    arx_front_stage u_front (
        .clk      (clk),
        .rst      (rst),
        .in_valid (start),
        .q_i      (q_in),
        .cm_i     (cm_in),
        .rot_i    (rot_sel),
        .out_valid(mid_valid),
        .q_o      (q_mid),
        .r2_o     (r2_mid)
    );

    arx_back_stage u_back (
        .clk     (clk),
        .rst     (rst),
        .in_valid(mid_valid),
        .q_i     (q_mid),
        .r2_i    (r2_mid),
        .done_o  (done),
        .q_o     (q_res)
    );

    assign a_out = q_res.a;
    assign b_out = q_res.b;
    assign c_out = q_res.c;
    assign d_out = q_res.d;

    // R7: every accepted start completes exactly two edges later
    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        start |-> ##2 done);

    // R7: no completion without a start two edges earlier
    p_no_spurious_done_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 2));

endmodule

// File: tb/arx_half_mix_bench.sv
module arx_half_mix_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int          due;
        logic [31:0] a, b, c, d;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        phase = 1'b0;
    logic [31:0] a_in = '0, b_in = '0, c_in = '0, d_in = '0, cm_in = '0;
    logic        done;
    logic [31:0] a_out, b_out, c_out, d_out;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    exp_t pend[$];
    exp_t hold_v;
    logic cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arx_half_mix u_arx_half_mix (
        .clk(clk), .rst(rst), .start(start), .phase(phase),
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in), .cm_in(cm_in),
        .done(done), .a_out(a_out), .b_out(b_out), .c_out(c_out), .d_out(d_out)
    );

    function automatic logic [31:0] rr(logic [31:0] x, int n);
        logic [63:0] dbl;
        dbl = {x, x} >> n;
        return dbl[31:0];
    endfunction

    function automatic exp_t half_ref(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                      logic [31:0] d, logic [31:0] m, logic ph);
        exp_t e;
        int   s1, s2;
        s1 = ph ? 8 : 16;
        s2 = ph ? 7 : 12;
        e.a = a + b + m;
        e.d = rr(d ^ e.a, s1);
        e.c = c + e.d;
        e.b = rr(b ^ e.c, s2);
        e.due = 0;
        return e;
    endfunction

    function automatic exp_t full_ref(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                      logic [31:0] d, logic [31:0] m0, logic [31:0] m1);
        exp_t e;
        a = a + b + m0;  d = rr(d ^ a, 16);
        c = c + d;       b = rr(b ^ c, 12);
        a = a + b + m1;  d = rr(d ^ a, 8);
        c = c + d;       b = rr(b ^ c, 7);
        e.a = a; e.b = b; e.c = c; e.d = d; e.due = 0;
        return e;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // Model: record each accepted request with its completion cycle
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            pend.delete();
        end else if (start) begin
            exp_t e;
            e = half_ref(a_in, b_in, c_in, d_in, cm_in, phase);
            e.due = cyc + 1;
            pend.push_back(e);
        end
    end

    // Compare every port on every cycle
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            logic exp_done;
            exp_done = 1'b0;
            if (pend.size() > 0 && pend[0].due == cyc) begin
                hold_v   = pend.pop_front();
                exp_done = 1'b1;
            end
            chk("R7/R8 done", {31'b0, done}, {31'b0, exp_done});
            chk(exp_done ? "R2 a_out" : "R9 a_out hold", a_out, hold_v.a);
            chk(exp_done ? "R5 b_out" : "R9 b_out hold", b_out, hold_v.b);
            chk(exp_done ? "R4 c_out" : "R9 c_out hold", c_out, hold_v.c);
            chk(exp_done ? "R3 d_out" : "R9 d_out hold", d_out, hold_v.d);
        end
    end

    task automatic issue(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                         logic [31:0] d, logic [31:0] m, logic ph);
        a_in = a; b_in = b; c_in = c; d_in = d; cm_in = m; phase = ph;
        start = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        hold_v = '{due: 0, a: '0, b: '0, c: '0, d: '0};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done in reset", {31'b0, done}, 32'd0);
        chk("R1 a_out in reset", a_out, 32'd0);
        chk("R1 d_out in reset", d_out, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after reset", {31'b0, done}, 32'd0);
        chk("R1 b_out after reset", b_out, 32'd0);
        cmp_on = 1'b1;

        // R6: fixed rotation pairs
        issue(32'h0, 32'h0, 32'h0, 32'h1, 32'h0, 1'b0);
        idle(2);
        chk("R6 phase0 b_out", b_out, 32'h0000_0010);
        chk("R6 phase0 d_out", d_out, 32'h0001_0000);
        issue(32'h0, 32'h0, 32'h0, 32'h1, 32'h0, 1'b1);
        idle(2);
        chk("R6 phase1 b_out", b_out, 32'h0002_0000);
        chk("R6 phase1 d_out", d_out, 32'h0100_0000);

        // R2/R4: carry wrap modulo 2^32
        issue(32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0, 32'h0000_0001, 1'b0);
        idle(2);
        chk("R2 wrap a_out", a_out, 32'h0000_0001);

        // R8: back-to-back starts, one landing in a done cycle
        issue(32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 32'h7654_3210, 32'hDEAD_BEEF, 1'b0);
        issue(32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444, 32'h5555_5555, 1'b1);
        issue(32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hFFFF_0000, 32'h0000_FFFF, 32'h1357_9BDF, 1'b0);
        issue(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF, 1'b1);
        idle(1);
        issue(32'hCAFE_F00D, 32'h0BAD_C0DE, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 1'b0);
        idle(3);

        // R10: two chained halves form the full mixing function
        begin
            exp_t fe;
            logic [31:0] ta, tb, tc, td;
            fe = full_ref(32'h6A09_E667, 32'hBB67_AE85, 32'h3C6E_F372, 32'hA54F_F53A,
                          32'h510E_527F, 32'h9B05_688C);
            issue(32'h6A09_E667, 32'hBB67_AE85, 32'h3C6E_F372, 32'hA54F_F53A, 32'h510E_527F, 1'b0);
            idle(2);
            ta = a_out; tb = b_out; tc = c_out; td = d_out;
            issue(ta, tb, tc, td, 32'h9B05_688C, 1'b1);
            idle(2);
            chk("R10 full a", a_out, fe.a);
            chk("R10 full b", b_out, fe.b);
            chk("R10 full c", c_out, fe.c);
            chk("R10 full d", d_out, fe.d);
        end

        // Mixed random traffic with gaps and bursts
        for (int i = 0; i < 300; i++) begin
            if (($urandom % 4) != 0)
                issue($urandom, $urandom, $urandom, $urandom, $urandom, 1'($urandom % 2));
            else
                idle(1);
        end
        idle(4);
        cmp_on = 1'b0;
        finish_run();
    end

endmodule